// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Register

This block collects event pulses from a multichannel HDLC DMA engine and from a per-port loopback change-of-state detector. It keeps them in two 16-bit sticky status registers, each with its own 16-bit interrupt mask. Every status bit latches when any channel pulses the matching event line. A bit stays set until the host reads the status register. The read returns the latched value and clears the register in the same cycle. An event that arrives during that read survives the clear.

The masked status of both banks drives two active-low interrupt pins. The host-bus interrupt follows every unmasked pending bit. The local-bus interrupt follows the same condition, but only while the local-bus configuration-mode input is high.

The host reaches the registers through a plain port with an address, a read strobe and a write strobe. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `evt_irq_regs`

## Requirements
- R1: After synchronous reset, both status registers and both mask registers hold 0, and both interrupt outputs are high (inactive).
- R2: A pulse on the DMA event line for bit b of any channel sets DMA status bit b. The bits are: 0 small-buffer read, 1 its error, 2 CRC error, 3 abort, 4 length violation, 5 receive overflow, 6 large-buffer read, 7 its error, 10 receive done-queue write, 11 its error, 12 transmit underflow, 13 transmit pending-queue read, 14 transmit done-queue write, 15 its error.
- R3: Bits 8 and 9 of the DMA status and of the DMA mask are unimplemented. They read as 0 whatever events or writes arrive.
- R4: A read strobe to a status address returns that register's value in rdata_o on the following cycle and clears the register. The register then stays 0 until a new event.
- R5: An event whose pulse coincides with a read strobe of its status register is not in that read's data. It remains set after the read and is returned by the next read.
- R6: Writes to a status address (0 for DMA, 2 for loopback) have no effect.
- R7: The mask registers are read-write: DMA mask at address 1, loopback mask at address 3. Reading a mask does not change it.
- R8: host_irq_n_o is low exactly while some status bit and its mask bit are both 1, in either bank. A mask bit of 0 blocks that status bit.
- R9: local_irq_n_o is low exactly while host_irq_n_o would be low and local_cfg_mode_i is high. Otherwise it is high.
- R10: The loopback bank sets status bit p on a pulse of lb_evt_i[p], for all 16 bits, and follows R4, R5 and R8 in the same way.
- R11: Reads of addresses 4 and above return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_evt_i | input | NUM_CH x 16 | Per-channel DMA event pulses, one bit per status position |
| lb_evt_i | input | 16 | Loopback detector change-of-state pulses, one per port |
| local_cfg_mode_i | input | 1 | High while the local bus is in configuration mode |
| addr_i | input | ADDR_W | Register word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_i |
| host_irq_n_o | output | 1 | Active-low host-bus interrupt |
| local_irq_n_o | output | 1 | Active-low local-bus interrupt |

## Verification
The bench builds the block with three channels and a 4-bit address. This is small enough to sweep every channel and every status bit of both banks through the full set, read and clear sequence. It also reaches every address, including all the decoded-empty ones. For each single-bit mask, the interrupt pins are checked with the configuration mode both low and high, against an unmasked event and a masked one. The read that coincides with an event and the writes aimed at the read-only status words are each driven on their own.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int REG_W = 16;

    // Bit positions of the DMA status word; neighbours decode these.
    localparam int BIT_RX_SB_RD   = 0;
    localparam int BIT_RX_SB_ERR  = 1;
    localparam int BIT_RX_CRC     = 2;
    localparam int BIT_RX_ABORT   = 3;
    localparam int BIT_RX_LEN     = 4;
    localparam int BIT_RX_OVF     = 5;
    localparam int BIT_RX_LB_RD   = 6;
    localparam int BIT_RX_LB_ERR  = 7;
    localparam int BIT_RX_DQ_WR   = 10;
    localparam int BIT_RX_DQ_ERR  = 11;
    localparam int BIT_TX_UNDR    = 12;
    localparam int BIT_TX_PQ_RD   = 13;
    localparam int BIT_TX_DQ_WR   = 14;
    localparam int BIT_TX_DQ_ERR  = 15;

    function automatic logic [REG_W-1:0] bitv(input int pos);
        return REG_W'(1) << pos;
    endfunction

    localparam logic [REG_W-1:0] DMA_IMPL =
        bitv(BIT_RX_SB_RD) | bitv(BIT_RX_SB_ERR) | bitv(BIT_RX_CRC) |
        bitv(BIT_RX_ABORT) | bitv(BIT_RX_LEN) | bitv(BIT_RX_OVF) |
        bitv(BIT_RX_LB_RD) | bitv(BIT_RX_LB_ERR) | bitv(BIT_RX_DQ_WR) |
        bitv(BIT_RX_DQ_ERR) | bitv(BIT_TX_UNDR) | bitv(BIT_TX_PQ_RD) |
        bitv(BIT_TX_DQ_WR) | bitv(BIT_TX_DQ_ERR);

    localparam logic [REG_W-1:0] LB_IMPL = '1;

    localparam int NUM_BANKS = 2;

    typedef enum logic [1:0] {
        SEL_DMA_STAT = 2'd0,
        SEL_DMA_MASK = 2'd1,
        SEL_LB_STAT  = 2'd2,
        SEL_LB_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] mask;
    } bank_view_t;

    function automatic reg_dec_t decode_addr(input logic [31:0] a);
        reg_dec_t d;
        d.hit = (a >> 2) == 32'd0;
        d.sel = reg_sel_e'(a[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/evt_or_reduce.sv
module evt_or_reduce #(
    parameter int NUM_CH = 4,
    parameter int W      = 16
) (
    input  logic [NUM_CH-1:0][W-1:0] ev_i,
    output logic [W-1:0]             any_o
);
    always_comb begin
        any_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            any_o = any_o | ev_i[c];
        end
    end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank
    import evt_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] ev_i,
    input  logic             clr_i,
    input  logic             mask_we_i,
    input  logic [REG_W-1:0] mask_wdata_i,
    output bank_view_t       view_o,
    output logic             pend_o
);
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] ev_impl;
    logic [REG_W-1:0] keep;

    assign ev_impl = ev_i & IMPL;
    assign keep    = clr_i ? '0 : status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= keep | ev_impl;
            if (mask_we_i) begin
                mask_q <= mask_wdata_i & IMPL;
            end
        end
    end

    assign view_o.status = status_q;
    assign view_o.mask   = mask_q;
    assign pend_o        = |(status_q & mask_q);

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|ev_impl) |=> ((status_q & $past(ev_impl)) == $past(ev_impl))); // R2
    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R4
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> ((status_q & ~$past(ev_impl)) == '0)); // R4
    AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (rst)
        (clr_i && |ev_impl) |=> (status_q == $past(ev_impl))); // R5
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((view_o.status | view_o.mask) & ~IMPL) == '0); // R3
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
    parameter int NB = 2
) (
    input  logic [NB-1:0] pend_i,
    input  logic          cfg_mode_i,
    output logic          host_irq_n_o,
    output logic          local_irq_n_o
);
    logic any_pend;

    assign any_pend      = |pend_i;
    assign host_irq_n_o  = ~any_pend;
    assign local_irq_n_o = ~(any_pend & cfg_mode_i);
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CH-1:0][REG_W-1:0] dma_evt_i,
    input  logic [REG_W-1:0]             lb_evt_i,
    input  logic                         local_cfg_mode_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         rd_i,
    input  logic                         wr_i,
    input  logic [REG_W-1:0]             wdata_i,
    output logic [REG_W-1:0]             rdata_o,
    output logic                         host_irq_n_o,
    output logic                         local_irq_n_o
);
    localparam int BANK_DMA = 0;
    localparam int BANK_LB  = 1;

    reg_dec_t         dec;
    logic [REG_W-1:0] dma_any;
    bank_view_t       views [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend;
    logic             clr_dma, clr_lb, we_dma_mask, we_lb_mask;
    logic [REG_W-1:0] rd_mux;

    assign dec = decode_addr(32'(addr_i));

    assign clr_dma     = rd_i && dec.hit && dec.sel == SEL_DMA_STAT;
    assign clr_lb      = rd_i && dec.hit && dec.sel == SEL_LB_STAT;
    assign we_dma_mask = wr_i && dec.hit && dec.sel == SEL_DMA_MASK;
    assign we_lb_mask  = wr_i && dec.hit && dec.sel == SEL_LB_MASK;

    evt_or_reduce #(.NUM_CH(NUM_CH), .W(REG_W)) u_or (
        .ev_i  (dma_evt_i),
        .any_o (dma_any)
    );

    sticky_bank #(.IMPL(DMA_IMPL)) u_dma_bank (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (dma_any),
        .clr_i        (clr_dma),
        .mask_we_i    (we_dma_mask),
        .mask_wdata_i (wdata_i),
        .view_o       (views[BANK_DMA]),
        .pend_o       (pend[BANK_DMA])
    );

    sticky_bank #(.IMPL(LB_IMPL)) u_lb_bank (
        .clk          (clk),
        .rst          (rst),
        .ev_i         (lb_evt_i),
        .clr_i        (clr_lb),
        .mask_we_i    (we_lb_mask),
        .mask_wdata_i (wdata_i),
        .view_o       (views[BANK_LB]),
        .pend_o       (pend[BANK_LB])
    );

    irq_drive #(.NB(NUM_BANKS)) u_irq (
        .pend_i        (pend),
        .cfg_mode_i    (local_cfg_mode_i),
        .host_irq_n_o  (host_irq_n_o),
        .local_irq_n_o (local_irq_n_o)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_DMA_STAT: rd_mux = views[BANK_DMA].status;
                SEL_DMA_MASK: rd_mux = views[BANK_DMA].mask;
                SEL_LB_STAT:  rd_mux = views[BANK_LB].status;
                SEL_LB_MASK:  rd_mux = views[BANK_LB].mask;
                default:      rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= rd_mux;
        end
    end

    AST_HOST_ON_DMA: assert property (@(posedge clk) disable iff (rst)
        (|(views[BANK_DMA].status & views[BANK_DMA].mask)) |-> !host_irq_n_o); // R8
    AST_HOST_ON_LB: assert property (@(posedge clk) disable iff (rst)
        (|(views[BANK_LB].status & views[BANK_LB].mask)) |-> !host_irq_n_o); // R10
    AST_LOCAL_GATED: assert property (@(posedge clk) disable iff (rst)
        !local_cfg_mode_i |-> local_irq_n_o); // R9
    AST_LOCAL_NEEDS_HOST: assert property (@(posedge clk) disable iff (rst)
        !local_irq_n_o |-> !host_irq_n_o); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_o)); // R4
endmodule

// File: tb/evt_irq_regs_tb_top.sv
`timescale 1ns/1ps
module evt_irq_regs_tb_top;
    localparam int NCH = 3;
    localparam int AW  = 4;
    localparam logic [15:0] IMPL_D = 16'hFCFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0][15:0] dma_evt = '0;
    logic [15:0] lb_evt = '0;
    logic        cfg = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        host_n, local_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .dma_evt_i        (dma_evt),
        .lb_evt_i         (lb_evt),
        .local_cfg_mode_i (cfg),
        .addr_i           (addr),
        .rd_i             (rd),
        .wr_i             (wr),
        .wdata_i          (wdata),
        .rdata_o          (rdata),
        .host_irq_n_o     (host_n),
        .local_irq_n_o    (local_n)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_read(input int a, output logic [15:0] d);
        @(negedge clk);
        addr = AW'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic reg_write(input int a, input logic [15:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_dma(input int ch, input logic [15:0] v);
        @(negedge clk);
        dma_evt[ch] = v;
        @(negedge clk);
        dma_evt = '0;
    endtask

    task automatic pulse_lb(input logic [15:0] v);
        @(negedge clk);
        lb_evt = v;
        @(negedge clk);
        lb_evt = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(host_n === 1'b1 && local_n === 1'b1, "R1 irq idle", {14'd0, host_n, local_n}, 16'h0003);
        for (int a = 0; a < 4; a++) begin
            reg_read(a, d);
            check(d === 16'h0, "R1 reset value", d, 16'h0);
        end

        // R2 R3 R4: every channel, every bit, set then clear on read
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < 16; b++) begin
                exp = (16'h1 << b) & IMPL_D;
                pulse_dma(c, 16'h1 << b);
                reg_read(0, d);
                check(d === exp, "R2 dma status bit", d, exp);
                reg_read(0, d);
                check(d === 16'h0, "R4 cleared after read", d, 16'h0);
            end
        end

        // R3: all events at once on one channel
        pulse_dma(1, 16'hFFFF);
        reg_read(0, d);
        check(d === IMPL_D, "R3 unused bits zero", d, IMPL_D);

        // R10: loopback bank sweep
        for (int b = 0; b < 16; b++) begin
            pulse_lb(16'h1 << b);
            reg_read(2, d);
            check(d === (16'h1 << b), "R10 lb status bit", d, 16'h1 << b);
            reg_read(2, d);
            check(d === 16'h0, "R10 lb cleared", d, 16'h0);
        end

        // R6: writes to status addresses ignored
        reg_write(0, 16'hFFFF);
        reg_write(2, 16'hFFFF);
        reg_read(0, d);
        check(d === 16'h0, "R6 dma status write ignored", d, 16'h0);
        reg_read(2, d);
        check(d === 16'h0, "R6 lb status write ignored", d, 16'h0);
        check(host_n === 1'b1, "R6 no irq", {15'd0, host_n}, 16'h1);

        // R7 R3: masks read-write, stable across reads
        reg_write(1, 16'hA5A5);
        reg_write(3, 16'h5A5A);
        for (int k = 0; k < 2; k++) begin
            reg_read(1, d);
            check(d === (16'hA5A5 & IMPL_D), "R7 dma mask readback", d, 16'hA5A5 & IMPL_D);
            reg_read(3, d);
            check(d === 16'h5A5A, "R7 lb mask readback", d, 16'h5A5A);
        end
        reg_write(1, 16'h0);
        reg_write(3, 16'h0);

        // R8 R9 R10: single-bit mask sweep over both banks
        for (int bank = 0; bank < 2; bank++) begin
            for (int b = 0; b < 16; b++) begin
                logic live;
                int nb;
                live = (bank == 1) ? 1'b1 : IMPL_D[b];
                nb = (b + 1) % 16;
                reg_write(bank == 0 ? 1 : 3, 16'h1 << b);
                cfg = 1'b0;
                if (bank == 0) pulse_dma(b % NCH, 16'h1 << b);
                else pulse_lb(16'h1 << b);
                check(host_n === !live, "R8 host irq unmasked", {15'd0, host_n}, {15'd0, !live});
                check(local_n === 1'b1, "R9 local gated off", {15'd0, local_n}, 16'h1);
                cfg = 1'b1;
                #1;
                check(local_n === !live, "R9 local in cfg mode", {15'd0, local_n}, {15'd0, !live});
                reg_read(bank == 0 ? 0 : 2, d);
                check(host_n === 1'b1 && local_n === 1'b1, "R4 irq drops after read", {14'd0, host_n, local_n}, 16'h3);
                if (bank == 0) pulse_dma(0, 16'h1 << nb);
                else pulse_lb(16'h1 << nb);
                check(host_n === 1'b1 && local_n === 1'b1, "R8 masked event no irq", {14'd0, host_n, local_n}, 16'h3);
                reg_read(bank == 0 ? 0 : 2, d);
                reg_write(bank == 0 ? 1 : 3, 16'h0);
            end
        end
        cfg = 1'b0;

        // R5: event during read survives the clear
        pulse_dma(2, 16'h0004);
        @(negedge clk);
        addr = AW'(0); rd = 1'b1; dma_evt[0] = 16'h0008;
        @(negedge clk);
        rd = 1'b0; dma_evt = '0;
        d = rdata;
        check(d === 16'h0004, "R5 read excludes coincident event", d, 16'h0004);
        reg_read(0, d);
        check(d === 16'h0008, "R5 coincident event kept", d, 16'h0008);
        pulse_lb(16'h0100);
        @(negedge clk);
        addr = AW'(2); rd = 1'b1; lb_evt = 16'h8000;
        @(negedge clk);
        rd = 1'b0; lb_evt = '0;
        d = rdata;
        check(d === 16'h0100, "R5 lb read excludes coincident", d, 16'h0100);
        reg_read(2, d);
        check(d === 16'h8000, "R5 lb coincident kept", d, 16'h8000);

        // R11: unmapped addresses read zero and clear nothing
        pulse_dma(0, 16'h0001);
        pulse_lb(16'h0002);
        for (int a = 4; a < 16; a++) begin
            reg_read(a, d);
            check(d === 16'h0, "R11 unmapped reads zero", d, 16'h0);
        end
        reg_read(0, d);
        check(d === 16'h0001, "R11 dma status untouched", d, 16'h0001);
        reg_read(2, d);
        check(d === 16'h0002, "R11 lb status untouched", d, 16'h0002);

        // R1: reset clears masks and status again
        reg_write(1, 16'hFFFF);
        pulse_dma(0, 16'h0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(host_n === 1'b1, "R1 irq after reset", {15'd0, host_n}, 16'h1);
        reg_read(1, d);
        check(d === 16'h0, "R1 mask after reset", d, 16'h0);
        reg_read(0, d);
        check(d === 16'h0, "R1 status after reset", d, 16'h0);

        finish_run();
    end
endmodule